// File: doc/BRIEF.md
# Nibble channel port unit

This unit holds the I/O side of a small 4-bit controller. An 8-bit output latch drives a bidirectional port that is handled as two 4-bit channels: channel A is the low nibble and channel B is the high nibble. The core issues one port operation at a time. It pulses `op_valid` and gives a 3-bit operation code, the current accumulator, the addressed RAM nibble and the carry flag. The unit then either rewrites one nibble of the latch or returns a new accumulator value with a load flag.

Reading a channel does not return the bare pins. The result is the pin value ANDed with the latch nibble and with the accumulator. A channel whose latch bits are at zero therefore reads back as zero. An 8-bit parallel input port is read through two operations: one takes the low nibble as it is, and the other takes the high nibble inverted. Two segment operations look up a 5-bit code in a 32-entry decode table. They permute the 8-bit table word and write half of it into one latch nibble, which drives display segments directly.

Top module: `nchan_port`

## Requirements
- R1: With `op_valid` high and `op_sel`=0 (output A), the latch low nibble takes `acc_in` on the next clock edge and the high nibble keeps its value. `r_latch_out` shows the new latch value from that same edge.
- R2: With `op_valid` high and `op_sel`=1 (output B), the latch high nibble takes `acc_in` on the next clock edge and the low nibble keeps its value.
- R3: With `op_valid` high and `op_sel`=2 (input A), `acc_load` is 1 and `acc_out` = `acc_in` AND `r_pins_in[3:0]` AND latch[3:0], in the same cycle.
- R4: With `op_valid` high and `op_sel`=3 (input B), `acc_load` is 1 and `acc_out` = `acc_in` AND `r_pins_in[7:4]` AND latch[7:4].
- R5: While `rst_n` is low, the latch is 8'hFF and `acc_load` is 0.
- R6: With `op_valid` high and `op_sel`=4, `acc_load` is 1 and `acc_out` = `p_in[3:0]`, unmodified.
- R7: With `op_valid` high and `op_sel`=5, `acc_load` is 1 and `acc_out` = NOT `p_in[7:4]`.
- R8: The segment table index is {`carry_in`, `ram_nib` AND NOT `acc_in`} XOR 5'h1F. The table word for index i has bit 7 = i[4], and bits 6..0 are the hex seven-segment pattern (g..a) of i[3:0]: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71 for digits 0 to F.
- R9: The segment result is the table word t reordered so that result bits 7..0 = t[7],t[5],t[3],t[1],t[0],t[2],t[4],t[6].
- R10: `op_sel`=6 (segment A) writes result bits 3..0 into the latch low nibble and keeps the high nibble. `op_sel`=7 (segment B) writes result bits 7..4 into the latch high nibble and keeps the low nibble.
- R11: Operations without a latch write leave the latch unchanged: `op_valid` low, and the input operations 2 to 5. `acc_load` is 0 unless `op_valid` is high with `op_sel` 2 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | One-cycle operation strobe |
| op_sel | input | 3 | Operation code (0..7, see R1 to R10) |
| acc_in | input | 4 | Current accumulator |
| ram_nib | input | 4 | Addressed RAM nibble |
| carry_in | input | 1 | Carry flag |
| p_in | input | 8 | Parallel input port |
| r_pins_in | input | 8 | Sensed levels of the bidirectional port pins |
| acc_out | output | 4 | New accumulator value (equals acc_in when not loading) |
| acc_load | output | 1 | Accumulator should take acc_out this cycle |
| r_latch_out | output | 8 | Output latch driving the port pins |

## Verification
The bench builds the unit with its defaults: 4-bit nibbles and a reset value of 8'hFF. These defaults give the two channel halves and the 32-entry segment table their sizes, so the bench can walk every table index through both segment operations. That walk covers the index inversion, the carry bit in index bit 4 and the full bit permutation on both nibbles. Channel reads are checked with latch nibbles that are partly cleared, which brings the AND with the latch within reach. A reset in the middle of the run is checked to return the latch to all ones.

// File: rtl/nchan_pkg.sv
// Shared operation codes for the nibble channel port unit.
// Assumes a 3-bit operation select supplied by the core's decoder.
package nchan_pkg;
    typedef enum logic [2:0] {
        OP_OUT_A  = 3'd0,
        OP_OUT_B  = 3'd1,
        OP_IN_A   = 3'd2,
        OP_IN_B   = 3'd3,
        OP_PAR_LO = 3'd4,
        OP_PAR_HI = 3'd5,
        OP_SEG_A  = 3'd6,
        OP_SEG_B  = 3'd7
    } chan_op_e;
endpackage

// File: rtl/nchan_seg_decode.sv
// Segment decoder: forms the 5-bit index from carry, RAM and accumulator,
// looks it up in a 32-entry constant table and permutes the 8-bit word.
// Assumes NIBW = 4 (8-bit table word, 5-bit index).
module nchan_seg_decode #(
    parameter int NIBW = 4
) (
    input  logic              carry_in,
    input  logic [NIBW-1:0]   ram_nib,
    input  logic [NIBW-1:0]   acc_in,
    output logic [2*NIBW-1:0] seg_word
);
    localparam int IDXW = NIBW + 1;
    localparam int WW   = 2 * NIBW;
    localparam int PERM [0:7] = '{6, 4, 2, 0, 1, 3, 5, 7};

    // Table content: top bit copies index bit 4, low seven bits are the hex glyph.
    function automatic logic [WW-1:0] table_word(input logic [IDXW-1:0] idx);
        logic [6:0] g;
        case (idx[3:0])
            4'h0: g = 7'h3F;  4'h1: g = 7'h06;  4'h2: g = 7'h5B;  4'h3: g = 7'h4F;
            4'h4: g = 7'h66;  4'h5: g = 7'h6D;  4'h6: g = 7'h7D;  4'h7: g = 7'h07;
            4'h8: g = 7'h7F;  4'h9: g = 7'h6F;  4'hA: g = 7'h77;  4'hB: g = 7'h7C;
            4'hC: g = 7'h39;  4'hD: g = 7'h5E;  4'hE: g = 7'h79;  default: g = 7'h71;
        endcase
        return {idx[4], g};
    endfunction

    logic [IDXW-1:0] index;
    logic [WW-1:0]   raw;

    // Index forming and table lookup.
    always_comb begin
        index = {carry_in, ram_nib & ~acc_in} ^ {IDXW{1'b1}};
        raw   = table_word(index);
    end

    // Fixed bit permutation of the table word.
    for (genvar k = 0; k < WW; k++) begin : g_perm
        assign seg_word[k] = raw[PERM[k]];
    end
endmodule

// File: rtl/nchan_latch.sv
// Output latch with independent low/high nibble write enables.
// Reset loads RESET_VAL; writes land on the clock edge that samples them.
module nchan_latch #(
    parameter int          NIBW      = 4,
    parameter logic [7:0]  RESET_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [NIBW-1:0]   lo_val,
    input  logic [NIBW-1:0]   hi_val,
    output logic [2*NIBW-1:0] q
);
    // Nibble-wise latch update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL[2*NIBW-1:0];
        end else begin
            if (wr_lo) q[NIBW-1:0]      <= lo_val;
            if (wr_hi) q[2*NIBW-1:NIBW] <= hi_val;
        end
    end
endmodule

// File: rtl/nchan_input_mux.sv
// Accumulator result for the four input operations; passes acc through
// and drops the load flag for every other operation or when idle.
module nchan_input_mux
    import nchan_pkg::*;
#(
    parameter int NIBW = 4
) (
    input  logic              op_valid,
    input  chan_op_e          op,
    input  logic [NIBW-1:0]   acc_in,
    input  logic [2*NIBW-1:0] r_pins_in,
    input  logic [2*NIBW-1:0] latch_q,
    input  logic [2*NIBW-1:0] p_in,
    output logic [NIBW-1:0]   acc_out,
    output logic              acc_load
);
    localparam int HI = 2 * NIBW - 1;

    // Select and combine the channel or parallel source.
    always_comb begin
        acc_out  = acc_in;
        acc_load = 1'b0;
        if (op_valid) begin
            case (op)
                OP_IN_A: begin
                    acc_out  = acc_in & r_pins_in[NIBW-1:0] & latch_q[NIBW-1:0];
                    acc_load = 1'b1;
                end
                OP_IN_B: begin
                    acc_out  = acc_in & r_pins_in[HI:NIBW] & latch_q[HI:NIBW];
                    acc_load = 1'b1;
                end
                OP_PAR_LO: begin
                    acc_out  = p_in[NIBW-1:0];
                    acc_load = 1'b1;
                end
                OP_PAR_HI: begin
                    acc_out  = ~p_in[HI:NIBW];
                    acc_load = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nchan_port.sv
// Nibble channel port unit top: decodes the strobed operation into latch
// nibble writes (direct or segment) and accumulator loads (channel or
// parallel input). Assumes one operation per strobe from the core.
module nchan_port
    import nchan_pkg::*;
#(
    parameter int         NIBW      = 4,
    parameter logic [7:0] RESET_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic [NIBW-1:0]   acc_in,
    input  logic [NIBW-1:0]   ram_nib,
    input  logic              carry_in,
    input  logic [2*NIBW-1:0] p_in,
    input  logic [2*NIBW-1:0] r_pins_in,
    output logic [NIBW-1:0]   acc_out,
    output logic              acc_load,
    output logic [2*NIBW-1:0] r_latch_out
);
    localparam int HI = 2 * NIBW - 1;

    chan_op_e          op;
    logic [2*NIBW-1:0] seg_word;
    logic              wr_lo, wr_hi;
    logic [NIBW-1:0]   lo_val, hi_val;

    assign op = chan_op_e'(op_sel);

    nchan_seg_decode #(.NIBW(NIBW)) u_seg (
        .carry_in (carry_in),
        .ram_nib  (ram_nib),
        .acc_in   (acc_in),
        .seg_word (seg_word)
    );

    // Nibble write enables and data: direct accumulator or segment half.
    always_comb begin
        wr_lo  = op_valid && (op == OP_OUT_A || op == OP_SEG_A);
        wr_hi  = op_valid && (op == OP_OUT_B || op == OP_SEG_B);
        lo_val = (op == OP_SEG_A) ? seg_word[NIBW-1:0] : acc_in;
        hi_val = (op == OP_SEG_B) ? seg_word[HI:NIBW]  : acc_in;
    end

    nchan_latch #(.NIBW(NIBW), .RESET_VAL(RESET_VAL)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .lo_val (lo_val),
        .hi_val (hi_val),
        .q      (r_latch_out)
    );

    nchan_input_mux #(.NIBW(NIBW)) u_in (
        .op_valid  (op_valid),
        .op        (op),
        .acc_in    (acc_in),
        .r_pins_in (r_pins_in),
        .latch_q   (r_latch_out),
        .p_in      (p_in),
        .acc_out   (acc_out),
        .acc_load  (acc_load)
    );
endmodule

// File: rtl/nchan_port_chk.sv
// Protocol checker for nchan_port, attached by bind below.
module nchan_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [2:0] op_sel,
    input logic [3:0] acc_in,
    input logic [7:0] p_in,
    input logic [7:0] r_pins_in,
    input logic [3:0] acc_out,
    input logic       acc_load,
    input logic [7:0] r_latch_out
);
    // R1
    out_a_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd0) |=>
            (r_latch_out[3:0] == $past(acc_in) && r_latch_out[7:4] == $past(r_latch_out[7:4])));
    // R2
    out_b_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd1) |=>
            (r_latch_out[7:4] == $past(acc_in) && r_latch_out[3:0] == $past(r_latch_out[3:0])));
    // R3
    in_a_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd2) |->
            (acc_load && acc_out == (acc_in & r_pins_in[3:0] & r_latch_out[3:0])));
    // R6
    par_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd4) |-> (acc_load && acc_out == p_in[3:0]));
    // R7
    par_hi_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd5) |-> (acc_load && (acc_out ^ p_in[7:4]) == 4'hF));
    // R10
    seg_b_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd7) |=> $stable(r_latch_out[3:0]));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || (op_sel >= 3'd2 && op_sel <= 3'd5)) |=> $stable(r_latch_out));
    // R11
    no_stray_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_sel < 3'd2 || op_sel > 3'd5) |-> !acc_load);
endmodule

bind nchan_port nchan_port_chk u_nchan_port_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_sel      (op_sel),
    .acc_in      (acc_in),
    .p_in        (p_in),
    .r_pins_in   (r_pins_in),
    .acc_out     (acc_out),
    .acc_load    (acc_load),
    .r_latch_out (r_latch_out)
);

// File: tb/nchan_port_bench.sv
`timescale 1ns/1ps
module nchan_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [3:0] acc_in = 4'h0;
    logic [3:0] ram_nib = 4'h0;
    logic       carry_in = 1'b0;
    logic [7:0] p_in = 8'h00;
    logic [7:0] r_pins_in = 8'h00;
    logic [3:0] acc_out;
    logic       acc_load;
    logic [7:0] r_latch_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] m_latch;

    always #4 clk = ~clk;

    nchan_port u_nchan_port (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .ram_nib(ram_nib), .carry_in(carry_in), .p_in(p_in),
        .r_pins_in(r_pins_in), .acc_out(acc_out), .acc_load(acc_load),
        .r_latch_out(r_latch_out)
    );

    // Stimulus vectors: {op, acc, ram, carry, p, pins}
    localparam logic [27:0] VEC [16] = '{
        {3'd0, 4'h5, 4'h0, 1'b0, 8'h00, 8'h00},
        {3'd1, 4'hA, 4'h0, 1'b0, 8'h00, 8'h00},
        {3'd2, 4'hF, 4'h0, 1'b0, 8'h00, 8'hFF},
        {3'd3, 4'hF, 4'h0, 1'b0, 8'h00, 8'h3C},
        {3'd0, 4'hF, 4'h0, 1'b0, 8'h00, 8'h00},
        {3'd1, 4'hF, 4'h0, 1'b0, 8'h00, 8'h00},
        {3'd2, 4'h9, 4'h0, 1'b0, 8'h00, 8'h0E},
        {3'd3, 4'hC, 4'h0, 1'b0, 8'h00, 8'h70},
        {3'd4, 4'h0, 4'h0, 1'b0, 8'hA7, 8'h00},
        {3'd5, 4'h0, 4'h0, 1'b0, 8'hA7, 8'h00},
        {3'd5, 4'h3, 4'h0, 1'b0, 8'h0F, 8'h00},
        {3'd6, 4'h0, 4'h3, 1'b0, 8'h00, 8'h00},
        {3'd7, 4'h6, 4'hF, 1'b1, 8'h00, 8'h00},
        {3'd0, 4'h0, 4'h0, 1'b0, 8'h00, 8'h00},
        {3'd2, 4'hF, 4'h0, 1'b0, 8'h00, 8'hFF},
        {3'd4, 4'h0, 4'h0, 1'b0, 8'h5C, 8'h00}
    };

    function automatic logic [6:0] ref_glyph(input logic [3:0] d);
        case (d)
            4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
            4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
            4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
            4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    // Reference segment result (R8, R9)
    function automatic logic [7:0] ref_seg(input logic c, input logic [3:0] r, input logic [3:0] a);
        logic [4:0] idx;
        logic [7:0] t;
        idx = {c, r & ~a} ^ 5'h1F;
        t = {idx[4], ref_glyph(idx[3:0])};
        return {t[7], t[5], t[3], t[1], t[0], t[2], t[4], t[6]};
    endfunction

    function automatic string req_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R1";  3'd1: return "R2";  3'd2: return "R3";  3'd3: return "R4";
            3'd4: return "R6";  3'd5: return "R7";  3'd6: return "R8 R9 R10";
            default: return "R8 R9 R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [3:0] a, input logic [3:0] r,
                         input logic c, input logic [7:0] p, input logic [7:0] pins);
        logic [3:0] e_acc;
        logic       e_load;
        logic [7:0] s;
        @(negedge clk);
        op_valid = 1'b1; op_sel = op; acc_in = a; ram_nib = r; carry_in = c;
        p_in = p; r_pins_in = pins;
        #1;
        e_acc = a; e_load = 1'b0;
        s = ref_seg(c, r, a);
        case (op)
            3'd2: begin e_acc = a & pins[3:0] & m_latch[3:0]; e_load = 1'b1; end
            3'd3: begin e_acc = a & pins[7:4] & m_latch[7:4]; e_load = 1'b1; end
            3'd4: begin e_acc = p[3:0];  e_load = 1'b1; end
            3'd5: begin e_acc = ~p[7:4]; e_load = 1'b1; end
            default: ;
        endcase
        check({req_tag(op), " R11 load"}, {7'd0, acc_load}, {7'd0, e_load});
        if (e_load) check({req_tag(op), " acc"}, {4'd0, acc_out}, {4'd0, e_acc});
        case (op)
            3'd0: m_latch[3:0] = a;
            3'd1: m_latch[7:4] = a;
            3'd6: m_latch[3:0] = s[3:0];
            3'd7: m_latch[7:4] = s[7:4];
            default: ;
        endcase
        @(negedge clk);
        op_valid = 1'b0;
        check({req_tag(op), " R11 latch"}, r_latch_out, m_latch);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_latch = 8'hFF;
        repeat (3) @(negedge clk);
        // R5 reset state
        check("R5 latch", r_latch_out, 8'hFF);
        check("R5 load", {7'd0, acc_load}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 after release", r_latch_out, 8'hFF);

        // Vector walk
        for (int i = 0; i < 16; i++) begin
            do_op(VEC[i][27:25], VEC[i][24:21], VEC[i][20:17], VEC[i][16],
                  VEC[i][15:8], VEC[i][7:0]);
        end

        // R8 R9 R10: every table index through both segment paths
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 16; r++) begin
                do_op(3'd6, 4'h0, r[3:0], c[0], 8'h00, 8'h00);
                do_op(3'd7, 4'h0, r[3:0], c[0], 8'h00, 8'h00);
            end
        end
        // R8 accumulator masking of the RAM nibble
        do_op(3'd6, 4'hF, 4'hF, 1'b0, 8'h00, 8'h00);
        do_op(3'd7, 4'hA, 4'hF, 1'b1, 8'h00, 8'h00);

        // R11 idle cycles with moving inputs leave the latch alone
        @(negedge clk);
        op_sel = 3'd0; acc_in = 4'h3; r_pins_in = 8'h00; p_in = 8'hFF;
        #1;
        check("R11 idle load", {7'd0, acc_load}, 8'h00);
        @(negedge clk);
        check("R11 idle latch", r_latch_out, m_latch);

        // R3 with cleared latch nibble reads zero despite high pins
        do_op(3'd0, 4'h0, 4'h0, 1'b0, 8'h00, 8'h00);
        do_op(3'd2, 4'hF, 4'h0, 1'b0, 8'h00, 8'hFF);

        // R5 reset mid-run
        do_op(3'd1, 4'h0, 4'h0, 1'b0, 8'h00, 8'h00);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R5 mid-run latch", r_latch_out, 8'hFF);
        rst_n = 1'b1;
        m_latch = 8'hFF;
        do_op(3'd3, 4'hF, 4'h0, 1'b0, 8'h00, 8'hFF);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule